// File: doc/BRIEF.md
# Synchronous Serial Port with Master and Slave Modes

This block moves one 8-bit word at a time over a three-wire serial link (clock, data out, data in) plus an optional select line. As a master it makes the serial clock from the system clock through one of three fixed dividers, or from an external timer pulse. As a slave it follows a serial clock arriving on a pin. In slave mode the select line can be made to gate the port, or it can be ignored.

Software hands a word to the port on a valid/ready write channel and collects the received word on a valid/ready read channel. The write channel has `tx_ready` high whenever the port is enabled in a supported mode, so a write is never stalled. A write that arrives while a word is still shifting is dropped and raises the collision flag. The read channel holds `rx_valid` and `rx_data` until `rx_ready` takes the word. The serial line cannot be paused, so a word that completes while the previous one is unread is lost and raises the overflow flag. A completion flag serves as the interrupt request. The collision, overflow and completion flags each stay set until their own clear pulse. When the port is disabled, all pin output enables are low and the pads are left to ordinary I/O use.

Top module: `spi_port`

## Requirements
- R1: In master mode `cfg_mode` 0000 the SCK period is 4 system clocks, in 0001 it is 16 and in 0010 it is 64 (parameters DIV_FAST, DIV_MID, DIV_SLOW).
- R2: In master mode `cfg_mode` 0011, SCK toggles once for each `tmr_pulse` seen during a transfer, so one SCK period spans two pulses.
- R3: SCK rests at the level of `cfg_cpol`. SDO changes only on the leading edge, which is the edge leaving the rest level. SDI is sampled on the trailing edge. A transfer has 8 bits and the MSB goes first. `sck_oe` is high in the master modes while the port is enabled.
- R4: In a master mode, a write accepted while no transfer is running starts a transfer of `tx_data`, and the 8 bits sampled from SDI then appear on `rx_data`.
- R5: When a transfer completes, `rx_valid` and `irq` go high. `irq` stays high until an `irq_clr` pulse.
- R6: A cycle with both `rx_valid` and `rx_ready` high clears `rx_valid`.
- R7: If a transfer completes while `rx_valid` is high and not being read, `ovf` goes high and `rx_data` keeps the older word. `ovf` stays high until `ovf_clr`.
- R8: A write accepted while a word is shifting sets `wcol`, and its data is dropped (the word on SDO is unchanged). `wcol` stays high until `wcol_clr`.
- R9: In slave mode `cfg_mode` 0100, a high `ss_n` drives `sdo_oe` low and resets the bit counter. A partly shifted word is thrown away and never completes.
- R10: In slave mode `cfg_mode` 0101, `ss_n` is ignored. `sdo_oe` is high and transfers complete whatever level `ss_n` has.
- R11: While `cfg_en` is low, or `cfg_mode` is outside 0000 to 0101, `tx_ready`, `sck_oe` and `sdo_oe` are low, and writes start nothing.
- R12: A slave shifts on `sck_i` by the edge rules of R3. It returns on SDO the word last written to it, and places the word received on SDI on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Port enable |
| cfg_mode | input | 4 | Mode select (see R1, R2, R9, R10) |
| cfg_cpol | input | 1 | SCK rest level |
| tx_data | input | WORD_W | Word to send |
| tx_valid | input | 1 | Write request |
| tx_ready | output | 1 | Write accepted when high with tx_valid |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | Received word waiting |
| rx_ready | input | 1 | Takes the received word |
| irq | output | 1 | Transfer complete flag |
| irq_clr | input | 1 | Clears irq |
| wcol | output | 1 | Write collision flag |
| wcol_clr | input | 1 | Clears wcol |
| ovf | output | 1 | Receive overflow flag |
| ovf_clr | input | 1 | Clears ovf |
| tmr_pulse | input | 1 | Timer pulse for mode 0011 |
| sck_i | input | 1 | Serial clock from pad (slave) |
| sck_o | output | 1 | Serial clock to pad (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n | input | 1 | Slave select, active low |

## Verification
The bench builds the port with its default parameters: dividers of 4, 16 and 64, two synchronizer stages and an 8-bit word. With these values every master rate can be measured directly, including the slowest at 512 clocks per word. A timer pulse every 5 clocks gives an expected SCK period of 10 for mode 0011. The slave runs are driven with a half period of 6 clocks, which is longer than the two-stage synchronizer delay. That margin lets the bench observe how the select gating aborts a partial word, and check that the following word is still aligned.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam logic [3:0] MODE_MST_FAST = 4'b0000;
  localparam logic [3:0] MODE_MST_MID  = 4'b0001;
  localparam logic [3:0] MODE_MST_SLOW = 4'b0010;
  localparam logic [3:0] MODE_MST_TMR  = 4'b0011;
  localparam logic [3:0] MODE_SLV_SEL  = 4'b0100;
  localparam logic [3:0] MODE_SLV_FREE = 4'b0101;

  typedef struct packed {
    logic sck;
    logic ss_n;
    logic sdi;
  } pin_in_t;

  function automatic logic mode_is_master(input logic [3:0] m);
    return m[3:2] == 2'b00;
  endfunction

  function automatic logic mode_is_slave(input logic [3:0] m);
    return (m == MODE_SLV_SEL) || (m == MODE_SLV_FREE);
  endfunction
endpackage

// File: rtl/spi_port_clkgen.sv
// Half-period tick source for master mode: fixed dividers or timer pulses.
module spi_port_clkgen #(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  input  logic       tmr_pulse,
  output logic       tick
);
  localparam int HALF_FAST = DIV_FAST / 2;
  localparam int HALF_MID  = DIV_MID / 2;
  localparam int HALF_SLOW = DIV_SLOW / 2;
  localparam int CW = (HALF_SLOW > 2) ? $clog2(HALF_SLOW) : 1;
  localparam logic [CW-1:0] LIM_FAST = CW'(HALF_FAST - 1);
  localparam logic [CW-1:0] LIM_MID  = CW'(HALF_MID - 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'(HALF_SLOW - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          use_tmr;
  logic          wrap;

  always_comb begin
    unique case (rate)
      2'b00:   lim = LIM_FAST;
      2'b01:   lim = LIM_MID;
      default: lim = LIM_SLOW;
    endcase
  end

  assign use_tmr = (rate == 2'b11);
  assign wrap    = (cnt == lim);
  assign tick    = run & (use_tmr ? tmr_pulse : wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || use_tmr || wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_port_sync.sv
// Multi-stage synchronizer for the slave-side pad inputs.
module spi_port_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_port_shifter.sv
// Word shifter shared by master and slave: drive on leading, sample on trailing.
module spi_port_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         lead,
  input  logic         trail,
  input  logic         sdi_bit,
  output logic         sdo_bit,
  output logic         active,
  output logic         done,
  output logic [W-1:0] word
);
  localparam int CNTW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

  logic [W-1:0]    shreg;
  logic [CNTW-1:0] cnt;
  logic            finish;

  assign finish = trail & active & (cnt == LAST);
  assign word   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      cnt     <= '0;
      active  <= 1'b0;
      done    <= 1'b0;
      sdo_bit <= 1'b0;
    end else begin
      done <= finish & ~clear;
      if (clear) begin
        cnt    <= '0;
        active <= 1'b0;
      end else begin
        if (lead) begin
          sdo_bit <= shreg[W-1];
          active  <= 1'b1;
        end
        if (trail && active) begin
          shreg <= {shreg[W-2:0], sdi_bit};
          if (finish) begin
            cnt    <= '0;
            active <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
      if (load) begin
        shreg   <= load_data;
        sdo_bit <= load_data[W-1];
      end
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int DIV_FAST    = 4,
  parameter int DIV_MID     = 16,
  parameter int DIV_SLOW    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [3:0]        cfg_mode,
  input  logic              cfg_cpol,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              irq,
  input  logic              irq_clr,
  output logic              wcol,
  input  logic              wcol_clr,
  output logic              ovf,
  input  logic              ovf_clr,
  input  logic              tmr_pulse,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              ss_n
);
  localparam logic [2:0] PIN_RST = 3'b010;

  logic is_m, is_s, run_en;
  logic wr, xfer_busy, start, collide, rd;
  logic m_run, ph, tick;
  pin_in_t pins_raw, pins_s;
  logic s_sck_d, s_edge, s_lead, s_trail;
  logic ss_block;
  logic lead, trail, sh_sdi, sh_clear;
  logic sh_active, sh_done;
  logic [WORD_W-1:0] sh_word;

  assign is_m   = mode_is_master(cfg_mode);
  assign is_s   = mode_is_slave(cfg_mode);
  assign run_en = cfg_en & (is_m | is_s);

  // write channel
  assign tx_ready  = run_en;
  assign wr        = tx_valid & tx_ready;
  assign xfer_busy = is_m ? m_run : sh_active;
  assign start     = wr & ~xfer_busy;
  assign collide   = wr & xfer_busy;
  assign rd        = rx_valid & rx_ready;

  // master clock
  spi_port_clkgen #(
    .DIV_FAST(DIV_FAST),
    .DIV_MID (DIV_MID),
    .DIV_SLOW(DIV_SLOW)
  ) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (m_run),
    .rate     (cfg_mode[1:0]),
    .tmr_pulse(tmr_pulse),
    .tick     (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 1'b0;
      ph    <= 1'b0;
    end else begin
      if (!run_en || !is_m) m_run <= 1'b0;
      else if (start)       m_run <= 1'b1;
      else if (sh_done)     m_run <= 1'b0;

      if (!run_en || !is_m || !m_run) ph <= 1'b0;
      else if (tick)                  ph <= ~ph;
    end
  end

  // slave pad inputs
  assign pins_raw = '{sck: sck_i, ss_n: ss_n, sdi: sdi};

  spi_port_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins_raw),
    .q    (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_sck_d <= 1'b0;
    else        s_sck_d <= pins_s.sck;
  end

  assign s_edge   = pins_s.sck ^ s_sck_d;
  assign s_lead   = s_edge & (s_sck_d == cfg_cpol);
  assign s_trail  = s_edge & (s_sck_d != cfg_cpol);
  assign ss_block = (cfg_mode == MODE_SLV_SEL) & pins_s.ss_n;

  // edge and data select
  assign lead     = is_m ? (tick & ~ph) : (is_s & s_lead & ~ss_block);
  assign trail    = is_m ? (tick & ph)  : (is_s & s_trail & ~ss_block);
  assign sh_sdi   = is_m ? sdi : pins_s.sdi;
  assign sh_clear = ~run_en | (is_s & ss_block);

  spi_port_shifter #(.W(WORD_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (sh_clear),
    .load     (start),
    .load_data(tx_data),
    .lead     (lead),
    .trail    (trail),
    .sdi_bit  (sh_sdi),
    .sdo_bit  (sdo),
    .active   (sh_active),
    .done     (sh_done),
    .word     (sh_word)
  );

  // pads
  assign sck_o  = cfg_cpol ^ ph;
  assign sck_oe = run_en & is_m;
  assign sdo_oe = run_en & (is_m | (is_s & ~ss_block));

  // read channel and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      irq      <= 1'b0;
      wcol     <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      if (sh_done) begin
        if (rx_valid && !rd) begin
          ovf <= 1'b1;
        end else begin
          rx_data  <= sh_word;
          rx_valid <= 1'b1;
        end
      end else if (rd) begin
        rx_valid <= 1'b0;
      end

      if (sh_done)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;

      if (collide)       wcol <= 1'b1;
      else if (wcol_clr) wcol <= 1'b0;

      if (sh_done && rx_valid && !rd) ovf <= 1'b1;
      else if (ovf_clr)               ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic [3:0]        cfg_mode,
  input logic              cfg_cpol,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic              irq,
  input logic              wcol,
  input logic              ovf,
  input logic              sck_o,
  input logic              m_run,
  input logic              s_active,
  input logic              done_w,
  input logic              ss_block
);
  // R1
  fast_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_mode == 4'b0000 && m_run && !$stable(sck_o)) |=> $stable(sck_o));

  // R3
  rest_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_mode[3:2] == 2'b00 && !m_run) |-> (sck_o == cfg_cpol));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_w));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !done_w) |=> !rx_valid);

  // R7
  overflow_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && rx_valid && !rx_ready) |=> (ovf && $stable(rx_data)));

  // R8
  collision_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol) |-> $past(tx_valid && tx_ready && (m_run || s_active)));

  // R9
  select_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_block |=> !s_active);
endmodule

bind spi_port spi_port_chk #(.WORD_W(WORD_W)) u_spi_port_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_en  (cfg_en),
  .cfg_mode(cfg_mode),
  .cfg_cpol(cfg_cpol),
  .tx_valid(tx_valid),
  .tx_ready(tx_ready),
  .rx_valid(rx_valid),
  .rx_ready(rx_ready),
  .rx_data (rx_data),
  .irq     (irq),
  .wcol    (wcol),
  .ovf     (ovf),
  .sck_o   (sck_o),
  .m_run   (m_run),
  .s_active(sh_active),
  .done_w  (sh_done),
  .ss_block(ss_block)
);

// File: tb/spi_port_bench.sv
`timescale 1ns/1ps
module spi_port_bench;
  localparam int TP    = 5;
  localparam int HS    = 6;
  localparam int LIMIT = 150000;
  localparam int NVEC  = 6;
  // {mode, cpol, tx byte, byte on SDI, expected SCK period}
  localparam logic [28:0] VEC [NVEC] = '{
    {4'b0000, 1'b0, 8'hA5, 8'h3C, 8'd4},
    {4'b0001, 1'b1, 8'h5A, 8'hC3, 8'd16},
    {4'b0010, 1'b0, 8'h81, 8'h7E, 8'd64},
    {4'b0011, 1'b1, 8'hF0, 8'h0F, 8'd10},
    {4'b0000, 1'b1, 8'h01, 8'h80, 8'd4},
    {4'b0001, 1'b0, 8'hFF, 8'h00, 8'd16}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_cpol = 1'b0;
  logic [3:0] cfg_mode = 4'b0000;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic irq_clr = 1'b0, wcol_clr = 1'b0, ovf_clr = 1'b0;
  logic tmr_pulse = 1'b0, sck_i = 1'b0, sdi = 1'b0, ss_n = 1'b1;
  logic tx_ready, rx_valid, irq, wcol, ovf, sck_o, sck_oe, sdo, sdo_oe;
  logic [7:0] rx_data;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .cfg_cpol(cfg_cpol), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .irq(irq), .irq_clr(irq_clr), .wcol(wcol),
    .wcol_clr(wcol_clr), .ovf(ovf), .ovf_clr(ovf_clr),
    .tmr_pulse(tmr_pulse), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .ss_n(ss_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_write(input logic [7:0] d);
    tx_data = d; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic pulse_read();
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic pulse_irq_clr();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  // bench plays the peripheral: drives SDI on leading edges, samples SDO on trailing edges
  task automatic xfer_master(input logic [3:0] mode, input logic cpol,
                             input logic [7:0] txb, input logic [7:0] misob,
                             input bit collide,
                             output logic [7:0] mosi, output int period);
    int bitn, lead1, ncyc;
    bit coll_done;
    logic prev;
    cfg_mode = mode; cfg_cpol = cpol; cfg_en = 1'b1;
    idle(2);
    prev = sck_o;
    pulse_write(txb);
    bitn = 0; lead1 = -1; period = 0; mosi = 8'h00; ncyc = 0; coll_done = 1'b0;
    while (bitn < 8 && ncyc < 20000) begin
      tmr_pulse = ((ncyc % TP) == 0);
      if (collide && bitn == 2 && !coll_done) begin
        tx_data = 8'h00; tx_valid = 1'b1; coll_done = 1'b1;
      end else begin
        tx_valid = 1'b0;
      end
      if (sck_o != prev) begin
        if (prev == cpol) begin
          sdi = misob[7-bitn];
          if (lead1 < 0) lead1 = ncyc;
          else if (period == 0) period = ncyc - lead1;
        end else begin
          mosi = {mosi[6:0], sdo};
          bitn++;
        end
        prev = sck_o;
      end
      @(negedge clk);
      ncyc++;
    end
    tx_valid = 1'b0; tmr_pulse = 1'b0;
    idle(4);
  endtask

  // bench plays the master toward a slave-mode port
  task automatic xfer_slave(input logic cpol, input logic [7:0] mosib,
                            input int nbits, output logic [7:0] miso);
    miso = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      sck_i = ~cpol; sdi = mosib[7-i];
      idle(HS);
      miso = {miso[6:0], sdo};
      sck_i = cpol;
      idle(HS);
    end
    idle(4);
  endtask

  initial begin
    @(posedge clk);
    while (cyc < LIMIT) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=%0d expected=<%0d cycles", cyc, LIMIT);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] mo, mi;
    int per;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // reset state
    check("R5 irq after reset", irq, 0);
    check("R6 rx_valid after reset", rx_valid, 0);
    check("R7 ovf after reset", ovf, 0);
    check("R8 wcol after reset", wcol, 0);
    check("R11 tx_ready after reset", tx_ready, 0);
    check("R11 sck_oe after reset", sck_oe, 0);
    check("R11 sdo_oe after reset", sdo_oe, 0);

    // R11: disabled port ignores a write
    pulse_write(8'h77);
    idle(40);
    check("R11 no completion while disabled", irq, 0);
    check("R11 no data while disabled", rx_valid, 0);
    // R11: unsupported mode code
    cfg_en = 1'b1; cfg_mode = 4'b0110;
    idle(2);
    check("R11 tx_ready in mode 0110", tx_ready, 0);
    check("R11 sck_oe in mode 0110", sck_oe, 0);
    check("R11 sdo_oe in mode 0110", sdo_oe, 0);
    cfg_en = 1'b0;

    // vector table: master rates, polarities, data patterns (R1 R2 R3 R4 R5 R6)
    for (int v = 0; v < NVEC; v++) begin
      xfer_master(VEC[v][28:25], VEC[v][24], VEC[v][23:16], VEC[v][15:8], 1'b0, mo, per);
      check("R3 MSB-first word on SDO", mo, VEC[v][23:16]);
      check("R4 word sampled from SDI", rx_data, VEC[v][15:8]);
      check("R5 rx_valid on completion", rx_valid, 1);
      check("R5 irq on completion", irq, 1);
      if (VEC[v][28:25] == 4'b0011) check("R2 SCK period from timer", per, VEC[v][7:0]);
      else                          check("R1 SCK period from divider", per, VEC[v][7:0]);
      check("R3 SCK at rest level", sck_o, VEC[v][24]);
      check("R3 sck_oe in master mode", sck_oe, 1);
      pulse_read();
      check("R6 read clears rx_valid", rx_valid, 0);
      check("R5 irq held until cleared", irq, 1);
      pulse_irq_clr();
      check("R5 irq_clr clears irq", irq, 0);
    end

    // R8: write during a transfer
    xfer_master(4'b0000, 1'b0, 8'h6D, 8'h92, 1'b1, mo, per);
    check("R8 wcol set", wcol, 1);
    check("R8 colliding data dropped", mo, 8'h6D);
    check("R8 received word intact", rx_data, 8'h92);
    idle(10);
    check("R8 wcol sticky", wcol, 1);
    wcol_clr = 1'b1; @(negedge clk); wcol_clr = 1'b0;
    check("R8 wcol_clr clears", wcol, 0);
    pulse_read(); pulse_irq_clr();

    // R7: second word before the first is read
    xfer_master(4'b0001, 1'b0, 8'h11, 8'hC4, 1'b0, mo, per);
    check("R7 no overflow on first word", ovf, 0);
    xfer_master(4'b0000, 1'b0, 8'h22, 8'h5B, 1'b0, mo, per);
    check("R7 ovf set", ovf, 1);
    check("R7 older word kept", rx_data, 8'hC4);
    check("R7 rx_valid still set", rx_valid, 1);
    idle(5);
    check("R7 ovf sticky", ovf, 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check("R7 ovf_clr clears", ovf, 0);
    pulse_read(); pulse_irq_clr();
    check("R6 read after overflow", rx_valid, 0);

    // R9: slave with select gating
    cfg_en = 1'b0; cfg_cpol = 1'b0; sck_i = 1'b0; ss_n = 1'b1;
    cfg_mode = 4'b0100; cfg_en = 1'b1;
    idle(5);
    check("R9 sdo_oe low while deselected", sdo_oe, 0);
    check("R11 sck_oe low in slave mode", sck_oe, 0);
    pulse_write(8'h3B);
    ss_n = 1'b0; idle(5);
    check("R9 sdo_oe high while selected", sdo_oe, 1);
    xfer_slave(1'b0, 8'hFF, 3, mi);
    ss_n = 1'b1; idle(5);
    check("R9 sdo_oe low after deselect", sdo_oe, 0);
    check("R9 partial word never completes", rx_valid, 0);
    check("R9 no irq from partial word", irq, 0);
    pulse_write(8'hC6);
    ss_n = 1'b0; idle(5);
    xfer_slave(1'b0, 8'h96, 8, mi);
    check("R9 counter restarted, word aligned", rx_data, 8'h96);
    check("R12 slave returns written word", mi, 8'hC6);
    check("R12 slave completion", irq, 1);
    pulse_read(); pulse_irq_clr();
    ss_n = 1'b1;

    // R10: slave ignoring select, opposite polarity
    cfg_en = 1'b0; cfg_cpol = 1'b1; sck_i = 1'b1;
    cfg_mode = 4'b0101; cfg_en = 1'b1;
    idle(5);
    check("R10 sdo_oe with ss_n high", sdo_oe, 1);
    pulse_write(8'h4E);
    xfer_slave(1'b1, 8'hA3, 8, mi);
    check("R10 word received with ss_n high", rx_data, 8'hA3);
    check("R12 slave SDO word, rest level high", mi, 8'h4E);
    check("R10 rx_valid", rx_valid, 1);
    pulse_read();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule